// File: doc/BRIEF.md
# UART Receive Character Recognizer

This block sits between a UART receiver and its receive FIFO. Every received character passes through it. It compares each character against three programmable match registers: a flow-resume (Xon) character, a flow-stop (Xoff) character and a wake-up/address character. A match sets a sticky bit in a status register that clears when read. The match also drives a one-cycle pulse toward the flow-control unit and can raise an interrupt request.

Each character class has its own optional strip control, so matched control characters can be kept out of the FIFO. A matched character that arrives with any receive error flag is always forwarded, so a corrupted byte that happens to look like a control character still reaches the host. Stripping never suppresses the recognition itself: the pulses, the status bits and the interrupt behave the same whether or not the character reaches the FIFO.

Host access uses a small synchronous register port with a 3-bit address. Read data is registered and appears one cycle after the read strobe.

Top module: `rxchar_matcher`

## Requirements
- R1: After reset, address 1 (resume char) reads 0x11, address 2 (stop char) reads 0x13, address 3 (wake char) reads 0x00, address 0 (control) reads 0x00, address 4 (status) reads 0x00, and fifo_wr, irq and all match pulses are low.
- R2: A character accepted with rx_valid that is not stripped appears on fifo_wr/fifo_data/fifo_err in the following cycle, with data and error flags unchanged.
- R3: A character equal to a match register sets a status bit (bit 0 resume, bit 1 stop, bit 2 wake) and drives the matching pulse output (resume_pulse, stop_pulse, wake_pulse) high for the cycle after the character is accepted.
- R4: A read of address 4 returns the status byte one cycle later and clears every bit that read returned.
- R5: A match accepted in the same cycle as a status read leaves its bit set after that read.
- R6: Control bit 0 strips matched resume and stop characters, and control bit 1 strips matched wake characters. A stripped character gives no fifo_wr.
- R7: A matched character with a nonzero error field is written to the FIFO even when its class is stripped.
- R8: A stripped character still sets its status bit and pulses its match output.
- R9: Control bits 3:2 (flow mode field) do not change stripping or forwarding.
- R10: irq is high exactly while a status bit is set whose enable is set in the control register: bit 4 enables resume, bit 5 stop, bit 6 wake.
- R11: Writing address 1, 2 or 3 replaces that match character. Later characters are compared against the new value, and reading the address returns it.
- R12: A character equal to several match registers sets all the corresponding status bits and pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address (0 control, 1 resume, 2 stop, 3 wake, 4 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| rx_valid | input | 1 | Received character valid |
| rx_data | input | 8 | Received character |
| rx_err | input | ERR_W | Receive error flags of the character |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Character to the FIFO |
| fifo_err | output | ERR_W | Error flags to the FIFO |
| resume_pulse | output | 1 | Resume character seen |
| stop_pulse | output | 1 | Stop character seen |
| wake_pulse | output | 1 | Wake character seen |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that rx_valid, rx_data and rx_err are stable across each clock edge. They also assume a status read is a single-cycle reg_rd with address 4, so "cleared after read" holds only when no new match lands in that cycle. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. It places a match together with a status read only in the scenario written for that coincidence, and the clear-after-read property excludes that case explicitly.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int CHAR_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int NUM_SLOTS = 3;

  localparam int SLOT_RESUME = 0;
  localparam int SLOT_STOP   = 1;
  localparam int SLOT_WAKE   = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_RESUME = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STOP   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_WAKE   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd4;

  typedef struct packed {
    logic       spare;
    logic [2:0] irq_en;      // wake, stop, resume
    logic [1:0] flow_mode;   // held for the flow-control unit only
    logic       strip_wake;
    logic       strip_flow;
  } ctrl_t;

  typedef logic [NUM_SLOTS-1:0][CHAR_W-1:0] slot_chars_t;
endpackage

// File: rtl/rxm_compare.sv
module rxm_compare
  import rxm_pkg::*;
(
  input  logic [CHAR_W-1:0] char_in,
  input  slot_chars_t       slot_chars,
  output logic [NUM_SLOTS-1:0] hit
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign hit[s] = (char_in == slot_chars[s]);
  end
endmodule

// File: rtl/rxm_regs.sv
module rxm_regs
  import rxm_pkg::*;
#(
  parameter logic [7:0] RESUME_INIT = 8'h11,
  parameter logic [7:0] STOP_INIT   = 8'h13,
  parameter logic [7:0] WAKE_INIT   = 8'h00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CHAR_W-1:0]    reg_wdata,
  input  logic [NUM_SLOTS-1:0] set_hits,
  output logic [CHAR_W-1:0]    reg_rdata,
  output ctrl_t                ctrl,
  output slot_chars_t          slot_chars,
  output logic [NUM_SLOTS-1:0] stat
);
  ctrl_t                ctrl_q, ctrl_n;
  slot_chars_t          chars_q, chars_n;
  logic [NUM_SLOTS-1:0] stat_q, stat_n;
  logic [CHAR_W-1:0]    rdata_q, rdata_n, rd_mux;
  logic                 rd_stat;

  assign rd_stat = reg_rd && (reg_addr == ADR_STAT);

  always_comb begin
    unique case (reg_addr)
      ADR_CTRL:   rd_mux = ctrl_q;
      ADR_RESUME: rd_mux = chars_q[SLOT_RESUME];
      ADR_STOP:   rd_mux = chars_q[SLOT_STOP];
      ADR_WAKE:   rd_mux = chars_q[SLOT_WAKE];
      ADR_STAT:   rd_mux = {{(CHAR_W-NUM_SLOTS){1'b0}}, stat_q};
      default:    rd_mux = '0;
    endcase
  end

  always_comb begin
    ctrl_n  = ctrl_q;
    chars_n = chars_q;
    if (reg_wr) begin
      case (reg_addr)
        ADR_CTRL:   ctrl_n = ctrl_t'(reg_wdata);
        ADR_RESUME: chars_n[SLOT_RESUME] = reg_wdata;
        ADR_STOP:   chars_n[SLOT_STOP]   = reg_wdata;
        ADR_WAKE:   chars_n[SLOT_WAKE]   = reg_wdata;
        default:    ;
      endcase
    end
    // clear what the read returns, keep matches landing now
    stat_n  = (rd_stat ? '0 : stat_q) | set_hits;
    rdata_n = reg_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q               <= '0;
      chars_q[SLOT_RESUME] <= RESUME_INIT;
      chars_q[SLOT_STOP]   <= STOP_INIT;
      chars_q[SLOT_WAKE]   <= WAKE_INIT;
      stat_q               <= '0;
      rdata_q              <= '0;
    end else begin
      ctrl_q  <= ctrl_n;
      chars_q <= chars_n;
      stat_q  <= stat_n;
      rdata_q <= rdata_n;
    end
  end

  assign reg_rdata  = rdata_q;
  assign ctrl       = ctrl_q;
  assign slot_chars = chars_q;
  assign stat       = stat_q;
endmodule

// File: rtl/rxm_forward.sv
module rxm_forward
  import rxm_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid,
  input  logic [CHAR_W-1:0]    rx_data,
  input  logic [ERR_W-1:0]     rx_err,
  input  logic [NUM_SLOTS-1:0] hit,
  input  logic                 strip_flow,
  input  logic                 strip_wake,
  output logic                 fifo_wr,
  output logic [CHAR_W-1:0]    fifo_data,
  output logic [ERR_W-1:0]     fifo_err,
  output logic [NUM_SLOTS-1:0] pulses
);
  logic                 wr_q, wr_n;
  logic [CHAR_W-1:0]    data_q;
  logic [ERR_W-1:0]     err_q;
  logic [NUM_SLOTS-1:0] pulse_q, pulse_n;
  logic                 strip_hit, clean;

  always_comb begin
    clean     = (rx_err == '0);
    strip_hit = (strip_flow && (hit[SLOT_RESUME] || hit[SLOT_STOP])) ||
                (strip_wake && hit[SLOT_WAKE]);
    wr_n      = rx_valid && !(strip_hit && clean);
    pulse_n   = rx_valid ? hit : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      pulse_q <= '0;
    end else begin
      wr_q    <= wr_n;
      pulse_q <= pulse_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= '0;
    end else if (rx_valid) begin
      data_q <= rx_data;
      err_q  <= rx_err;
    end
  end

  assign fifo_wr   = wr_q;
  assign fifo_data = data_q;
  assign fifo_err  = err_q;
  assign pulses    = pulse_q;
endmodule

// File: rtl/rxchar_matcher.sv
module rxchar_matcher
  import rxm_pkg::*;
#(
  parameter int         ERR_W       = 3,
  parameter logic [7:0] RESUME_INIT = 8'h11,
  parameter logic [7:0] STOP_INIT   = 8'h13,
  parameter logic [7:0] WAKE_INIT   = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic [ERR_W-1:0]  rx_err,
  output logic              fifo_wr,
  output logic [7:0]        fifo_data,
  output logic [ERR_W-1:0]  fifo_err,
  output logic              resume_pulse,
  output logic              stop_pulse,
  output logic              wake_pulse,
  output logic              irq
);
  ctrl_t                ctrl;
  slot_chars_t          slot_chars;
  logic [NUM_SLOTS-1:0] hit, set_hits, stat_vec, pulses;

  rxm_compare u_cmp (
    .char_in    (rx_data),
    .slot_chars (slot_chars),
    .hit        (hit)
  );

  assign set_hits = rx_valid ? hit : '0;

  rxm_regs #(
    .RESUME_INIT (RESUME_INIT),
    .STOP_INIT   (STOP_INIT),
    .WAKE_INIT   (WAKE_INIT)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .set_hits   (set_hits),
    .reg_rdata  (reg_rdata),
    .ctrl       (ctrl),
    .slot_chars (slot_chars),
    .stat       (stat_vec)
  );

  rxm_forward #(.ERR_W(ERR_W)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_err     (rx_err),
    .hit        (hit),
    .strip_flow (ctrl.strip_flow),
    .strip_wake (ctrl.strip_wake),
    .fifo_wr    (fifo_wr),
    .fifo_data  (fifo_data),
    .fifo_err   (fifo_err),
    .pulses     (pulses)
  );

  assign resume_pulse = pulses[SLOT_RESUME];
  assign stop_pulse   = pulses[SLOT_STOP];
  assign wake_pulse   = pulses[SLOT_WAKE];
  assign irq          = |(stat_vec & ctrl.irq_en);
endmodule

// File: rtl/rxm_checker.sv
module rxm_checker #(
  parameter int ERR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic             rx_valid,
  input logic [7:0]       rx_data,
  input logic [ERR_W-1:0] rx_err,
  input logic             fifo_wr,
  input logic [7:0]       fifo_data,
  input logic             resume_pulse,
  input logic             stop_pulse,
  input logic             wake_pulse,
  input logic             irq,
  input logic [2:0]       stat_vec
);
  logic rd_stat;
  assign rd_stat = reg_rd && (reg_addr == 3'd4);

  assert_write_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid));

  assert_error_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_err != '0) |=> (fifo_wr && fifo_data == $past(rx_data)));

  assert_pulse_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_pulse |-> stat_vec[0]) and (stop_pulse |-> stat_vec[1]) and (wake_pulse |-> stat_vec[2]));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !rx_valid) |=> (stat_vec == 3'b000));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stat |=> ((stat_vec & $past(stat_vec)) == $past(stat_vec)));

  assert_irq_needs_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_vec != 3'b000));
endmodule

bind rxchar_matcher rxm_checker #(.ERR_W(ERR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .rx_valid     (rx_valid),
  .rx_data      (rx_data),
  .rx_err       (rx_err),
  .fifo_wr      (fifo_wr),
  .fifo_data    (fifo_data),
  .resume_pulse (resume_pulse),
  .stop_pulse   (stop_pulse),
  .wake_pulse   (wake_pulse),
  .irq          (irq),
  .stat_vec     (stat_vec)
);

// File: tb/rxchar_matcher_test.sv
module rxchar_matcher_test;
  localparam int ERR_W = 3;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_data = '0;
  logic [ERR_W-1:0] rx_err = '0;
  logic             fifo_wr;
  logic [7:0]       fifo_data;
  logic [ERR_W-1:0] fifo_err;
  logic             resume_pulse, stop_pulse, wake_pulse, irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  rxchar_matcher #(.ERR_W(ERR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_err(fifo_err),
    .resume_pulse(resume_pulse), .stop_pulse(stop_pulse),
    .wake_pulse(wake_pulse), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // outputs of the sent character are valid when this returns
  task automatic send(input logic [7:0] c, input logic [ERR_W-1:0] e);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = c; rx_err = e;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic int pv();
    return {29'd0, wake_pulse, stop_pulse, resume_pulse};
  endfunction

  task automatic t_reset();
    logic [7:0] v;
    check(fifo_wr == 0 && irq == 0 && pv() == 0, "R1 outputs", {fifo_wr, irq}, 0);
    rd_reg(3'd1, v); check(v == 8'h11, "R1 resume char", v, 8'h11);
    rd_reg(3'd2, v); check(v == 8'h13, "R1 stop char", v, 8'h13);
    rd_reg(3'd3, v); check(v == 8'h00, "R1 wake char", v, 0);
    rd_reg(3'd0, v); check(v == 8'h00, "R1 control", v, 0);
    rd_reg(3'd4, v); check(v == 8'h00, "R1 status", v, 0);
  endtask

  task automatic t_pass();
    logic [7:0] v;
    send(8'h41, 3'b000);
    check(fifo_wr && fifo_data == 8'h41 && fifo_err == 0, "R2 clean char", fifo_data, 8'h41);
    check(pv() == 0, "R2 no pulse", pv(), 0);
    send(8'h42, 3'b101);
    check(fifo_wr && fifo_data == 8'h42 && fifo_err == 3'b101, "R2 error kept", fifo_err, 5);
    @(negedge clk);
    check(!fifo_wr, "R2 single write", fifo_wr, 0);
    rd_reg(3'd4, v); check(v == 0, "R2 no status", v, 0);
  endtask

  task automatic t_match();
    logic [7:0] v;
    send(8'h11, 3'b000);
    check(pv() == 1 && fifo_wr, "R3 resume pulse", pv(), 1);
    @(negedge clk);
    check(pv() == 0, "R3 pulse one cycle", pv(), 0);
    rd_reg(3'd4, v); check(v == 8'h01, "R4 status read", v, 1);
    rd_reg(3'd4, v); check(v == 8'h00, "R4 cleared", v, 0);
    send(8'h13, 3'b000); check(pv() == 2, "R3 stop pulse", pv(), 2);
    send(8'h00, 3'b000); check(pv() == 4, "R3 wake pulse", pv(), 4);
    rd_reg(3'd4, v); check(v == 8'h06, "R3 status bits", v, 6);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr_reg(3'd0, 8'h10);
    send(8'h13, 3'b000);
    @(negedge clk); check(!irq, "R10 masked", irq, 0);
    send(8'h11, 3'b000);
    @(negedge clk); check(irq, "R10 enabled", irq, 1);
    rd_reg(3'd4, v); check(v == 8'h03, "R10 status", v, 3);
    check(!irq, "R10 drop after read", irq, 0);
    wr_reg(3'd0, 8'h00);
  endtask

  task automatic t_program();
    logic [7:0] v;
    wr_reg(3'd1, 8'h55);
    send(8'h11, 3'b000); check(pv() == 0, "R11 old char ignored", pv(), 0);
    send(8'h55, 3'b000); check(pv() == 1, "R11 new char", pv(), 1);
    rd_reg(3'd1, v); check(v == 8'h55, "R11 readback", v, 8'h55);
    wr_reg(3'd1, 8'h11);
    rd_reg(3'd4, v);
  endtask

  task automatic t_strip();
    logic [7:0] v;
    wr_reg(3'd0, 8'h01);
    send(8'h11, 3'b000);
    check(!fifo_wr, "R6 resume stripped", fifo_wr, 0);
    check(pv() == 1, "R8 pulse when stripped", pv(), 1);
    send(8'h00, 3'b000); check(fifo_wr, "R6 wake kept", fifo_wr, 1);
    wr_reg(3'd0, 8'h02);
    send(8'h00, 3'b000);
    check(!fifo_wr && pv() == 4, "R6 wake stripped", {fifo_wr, pv()}, 4);
    send(8'h13, 3'b000); check(fifo_wr, "R6 stop kept", fifo_wr, 1);
    rd_reg(3'd4, v); check(v == 8'h07, "R8 status when stripped", v, 7);
  endtask

  task automatic t_err();
    logic [7:0] v;
    wr_reg(3'd0, 8'h03);
    send(8'h13, 3'b010);
    check(fifo_wr && fifo_data == 8'h13 && fifo_err == 3'b010, "R7 error forwarded", fifo_wr, 1);
    check(pv() == 2, "R7 pulse", pv(), 2);
    rd_reg(3'd4, v);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wr_reg(3'd0, 8'h0D);
    send(8'h13, 3'b000); check(!fifo_wr, "R9 strip with mode 3", fifo_wr, 0);
    wr_reg(3'd0, 8'h0C);
    send(8'h13, 3'b000); check(fifo_wr, "R9 no strip with mode 3", fifo_wr, 1);
    wr_reg(3'd0, 8'h00);
    rd_reg(3'd4, v);
  endtask

  task automatic t_coincide();
    logic [7:0] v;
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd4;
    rx_valid = 1'b1; rx_data = 8'h13; rx_err = '0;
    @(negedge clk);
    reg_rd = 1'b0; rx_valid = 1'b0;
    check(reg_rdata == 8'h00, "R5 old status", reg_rdata, 0);
    rd_reg(3'd4, v); check(v == 8'h02, "R5 new match kept", v, 2);
  endtask

  task automatic t_multi();
    logic [7:0] v;
    wr_reg(3'd3, 8'h13);
    send(8'h13, 3'b000); check(pv() == 6, "R12 both pulses", pv(), 6);
    rd_reg(3'd4, v); check(v == 8'h06, "R12 both bits", v, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass();
    t_match();
    t_irq();
    t_program();
    t_strip();
    t_err();
    t_mode();
    t_coincide();
    t_multi();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule